// File: doc/BRIEF.md
# PLL Control and Status Register

This block is a byte-wide control and status register on a simple CPU peripheral bus. It serves a clock generator's phase-locked loop. It stores three software-owned bits: an interrupt enable, a PLL power switch and a base clock select. It also keeps a lock-change flag that hardware sets.

The lock input from the PLL is brought into the bus clock domain through a synchronizer. Each change of its level, rising or falling, sets the flag. A CPU read of the register clears the flag. While both the flag and the enable are 1, and auto mode is on, the interrupt request is raised.

An auto-mode input comes from a companion bandwidth register. While auto mode is off, the enable cannot be written, and both the enable and the flag read as zero.

Top module: `pll_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x2F, `irq_o` is 0, `pll_on_o` is 1 and `base_sel_o` is 0.
- R2: The read byte is {enable (bit 7), flag (bit 6), pll_on (bit 5), base_sel (bit 4), 4'b1111}. A write at the register address loads bit 5 into `pll_on_o` and bit 4 into `base_sel_o`, effective from the next rising edge.
- R3: A change of `lock_i` in either direction sets the flag. If `lock_i` changes before rising edge k, the flag still reads 0 after edge k+1 and reads 1 after edge k+2.
- R4: A read strobe at the register address returns the current flag and clears it at the next rising edge.
- R5: When a lock change sets the flag on the same edge as a clearing read, the flag ends up set.
- R6: `irq_o` is 1 exactly while the flag, the enable and `auto_i` are all 1. It is due on the same edge as the flag or the enable becomes 1.
- R7: While `auto_i` is 0, writes to bit 7 leave the enable unchanged and bit 7 reads 0.
- R8: While `auto_i` is 0, bit 6 reads 0. The flag is still set and kept internally, and it shows again once `auto_i` returns to 1.
- R9: Writes to bit 6 and bits 3..0 have no effect on the register.
- R10: A write or read at any other address changes no state, clears no flag, and returns read data 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Peripheral address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| lock_i | input | 1 | Asynchronous PLL lock indication |
| auto_i | input | 1 | Auto mode from the bandwidth register |
| rdata_o | output | 8 | Read data, combinational from address |
| irq_o | output | 1 | Interrupt request |
| pll_on_o | output | 1 | PLL power switch |
| base_sel_o | output | 1 | Base clock select |

## Verification
Read data is combinational, so each read is sampled during the same cycle as its strobe. A clear from a read or a change from a write shows up one rising edge later.

A change on `lock_i` must cross two synchronizer stages and the flag register. The bench therefore drives the lock on a falling edge and checks the flag after two rising edges, expecting 0, and again after three, expecting 1.

The set-versus-clear test places the read strobe in the cycle that ends on the third edge. All other stimulus is driven on falling edges and sampled one time unit later, so the bench never samples at an active edge.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned FLAG_BIT = 6;
  localparam int unsigned ON_BIT   = 5;
  localparam int unsigned SEL_BIT  = 4;
  localparam int unsigned FILL_W   = 4;
  localparam logic [FILL_W-1:0] FILL_VAL = '1;
  localparam logic EN_RST  = 1'b0;
  localparam logic ON_RST  = 1'b1;
  localparam logic SEL_RST = 1'b0;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  output logic chg_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= lock_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], lock_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign chg_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/pll_lock_flag.sv
module pll_lock_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins so a lock event is never lost
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
endmodule

// File: rtl/pll_ctrl_bits.sv
module pll_ctrl_bits
  import pll_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              auto_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o,
  output logic              on_o,
  output logic              sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      en_o  <= EN_RST;
      on_o  <= ON_RST;
      sel_o <= SEL_RST;
    end else if (we_i) begin
      if (auto_i) en_o <= wdata_i[EN_BIT];
      on_o  <= wdata_i[ON_BIT];
      sel_o <= wdata_i[SEL_BIT];
    end
endmodule

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg
  import pll_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1C,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lock_i,
  input  logic              auto_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              pll_on_o,
  output logic              base_sel_o
);
  logic hit_w, wr_hit_w, rd_hit_w, chg_w, flag_w, en_w;

  assign hit_w    = (addr_i == REG_ADDR);
  assign wr_hit_w = wr_en_i & hit_w;
  assign rd_hit_w = rd_en_i & hit_w;

  pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .lock_i, .chg_o(chg_w)
  );

  pll_lock_flag u_flag (
    .clk_i, .rst_ni, .set_i(chg_w), .clr_i(rd_hit_w), .flag_o(flag_w)
  );

  pll_ctrl_bits u_bits (
    .clk_i, .rst_ni, .we_i(wr_hit_w), .auto_i, .wdata_i,
    .en_o(en_w), .on_o(pll_on_o), .sel_o(base_sel_o)
  );

  always_comb begin
    rdata_o = '0;
    if (hit_w) begin
      rdata_o[EN_BIT]     = en_w & auto_i;
      rdata_o[FLAG_BIT]   = flag_w & auto_i;
      rdata_o[ON_BIT]     = pll_on_o;
      rdata_o[SEL_BIT]    = base_sel_o;
      rdata_o[FILL_W-1:0] = FILL_VAL;
    end
  end

  assign irq_o = flag_w & en_w & auto_i;
endmodule

// File: rtl/pll_ctrl_reg_chk.sv
module pll_ctrl_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       auto_i,
  input logic       wr_en_i,
  input logic       rd_hit_w,
  input logic       wr_hit_w,
  input logic       chg_w,
  input logic       flag_w,
  input logic       en_w,
  input logic       irq_o,
  input logic       pll_on_o,
  input logic       base_sel_o,
  input logic [7:0] rdata_o
);
  // R2
  fill_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit_w |-> rdata_o[3:0] == 4'hF);
  // R4
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit_w && !chg_w) |=> !flag_w);
  // R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_w |=> flag_w);
  // R6
  irq_auto_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> auto_i);
  // R7
  en_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_w && !auto_i) |=> en_w == $past(en_w));
  // R8
  hide_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_i |-> rdata_o[7:6] == 2'b00);
  // R10
  miss_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_hit_w) |=> $stable({pll_on_o, base_sel_o, en_w}));
endmodule

bind pll_ctrl_reg pll_ctrl_reg_chk chk_i (
  .clk_i, .rst_ni, .auto_i, .wr_en_i, .rd_hit_w, .wr_hit_w, .chg_w,
  .flag_w, .en_w, .irq_o, .pll_on_o, .base_sel_o, .rdata_o
);

// File: tb/pll_ctrl_reg_tb_top.sv
module pll_ctrl_reg_tb_top;
  localparam logic [7:0] RA = 8'h1C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = RA;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic       lock = 1'b0, auto_m = 1'b1;
  logic [7:0] rdata;
  logic       irq, pll_on, base_sel;

  int checks = 0, errors = 0;
  logic m_en = 1'b0, m_on = 1'b1, m_sel = 1'b0, m_flag = 1'b0;

  always #5 clk = ~clk;

  pll_ctrl_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .lock_i(lock), .auto_i(auto_m),
    .rdata_o(rdata), .irq_o(irq), .pll_on_o(pll_on), .base_sel_o(base_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expv();
    return {m_en & auto_m, m_flag & auto_m, m_on, m_sel, 4'hF};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = RA;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0; addr = RA;
  endtask

  task automatic toggle_and_settle();
    @(negedge clk);
    lock = ~lock;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 rdata", rdata, 8'h2F);
    chk("R1 irq", irq, 1'b0);
    chk("R1 pll_on", pll_on, 1'b1);
    chk("R1 base_sel", base_sel, 1'b0);

    // R2 R7 R9 sweep over every byte in both auto modes
    for (int am = 0; am < 2; am++) begin
      auto_m = am[0];
      for (int d = 0; d < 256; d++) begin
        wr(RA, d[7:0]);
        if (auto_m) m_en = d[7];
        m_on = d[5]; m_sel = d[4];
        chk("R2 pll_on", pll_on, m_on);
        chk("R2 base_sel", base_sel, m_sel);
        rd(RA, v);
        chk(auto_m ? "R2 R9 readback" : "R7 R9 readback", v, expv());
      end
    end
    auto_m = 1'b1;
    #1 chk("R7 enable kept", rdata[7], m_en);

    // R10 other addresses: no write effect, read returns zero
    for (int a = 0; a < 256; a += 17) begin
      if (a[7:0] == RA) continue;
      wr(a[7:0], ~expv());
      rd(a[7:0], v);
      chk("R10 miss read", v, 8'h00);
      rd(RA, v);
      chk("R10 state kept", v, expv());
    end

    // R3 latency, rising edge
    wr(RA, 8'h00); m_en = 0; m_on = 0; m_sel = 0;
    @(negedge clk); lock = 1'b1;
    repeat (2) @(negedge clk);
    #1 chk("R3 not yet", rdata[6], 1'b0);
    @(negedge clk);
    #1 chk("R3 rise sets", rdata[6], 1'b1);
    m_flag = 1;
    chk("R6 irq off when disabled", irq, 1'b0);
    // R4 read returns flag then clears
    rd(RA, v); chk("R4 read shows flag", v[6], 1'b1); m_flag = 0;
    rd(RA, v); chk("R4 cleared", v[6], 1'b0);
    // R10 miss read does not clear
    toggle_and_settle(); m_flag = 1;
    rd(8'h1D, v);
    rd(RA, v); chk("R10 miss read keeps flag", v[6], 1'b1);
    rd(RA, v); chk("R3 falling edge flag cleared after read", v[6], 1'b0);

    // R6 interrupt with enable
    wr(RA, 8'h80); m_en = 1;
    chk("R6 idle irq", irq, 1'b0);
    toggle_and_settle();
    #1 chk("R6 irq raised", irq, 1'b1);
    auto_m = 1'b0;
    #1 chk("R6 irq masked by auto", irq, 1'b0);
    chk("R8 flag hidden", rdata[7:6], 2'b00);
    auto_m = 1'b1;
    #1 chk("R8 flag retained", rdata[6], 1'b1);
    rd(RA, v);
    #1 chk("R6 irq cleared by read", irq, 1'b0);

    // R8 flag set while auto off
    auto_m = 1'b0;
    toggle_and_settle();
    rd(RA, v); chk("R8 reads zero", v[7:6], 2'b00);
    auto_m = 1'b1;
    #1 chk("R8 cleared by hidden read", rdata[6], 1'b0);

    // R5 set and clear on the same edge
    @(negedge clk); lock = ~lock;
    repeat (2) @(negedge clk);
    rd_en = 1'b1;
    #1 chk("R5 pre-read", rdata[6], 1'b0);
    @(negedge clk); rd_en = 1'b0;
    #1 chk("R5 set wins", rdata[6], 1'b1);
    chk("R5 irq", irq, 1'b1);

    // R9 write flag bit cannot clear it
    wr(RA, 8'h80);
    #1 chk("R9 flag not writable", rdata[6], 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule